// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small processor built around a single 16-bit accumulator and a private store of 4096 words of 16 bits. Every instruction word carries a 4-bit operation code in its top bits and a 12-bit direct operand address in the remaining bits. Execution is driven by a timing generator that steps through numbered microcycles, one per clock. Each register load is enabled only when the decoded operation matches and the right microcycle strobe is active.

Every instruction starts with the same three-microcycle fetch. The execute part then takes one to three further microcycles, depending on the operation. Programs and data are written into the store through a load port while the core is held in reset. The core talks to the outside through an input register that captures a word on a strobe, and an output register with a one-cycle valid pulse. A halted flag rises when the halt operation runs and freezes the core until the next reset.

Top module: `acpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, halt flag, output register and output valid, and restarts the timing at microcycle 1, so execution begins at address 0.
- R2: Fetch uses three microcycles. In microcycle 1 the address register takes PC. In microcycle 2 the data register takes the stored word and PC increments. In microcycle 3 the opcode register takes bits 15:12. Total lengths per instruction are: load (code 0), add (code 2) and AND (code 3) take 6 cycles; store (code 1) takes 5 cycles; all other codes take 4 cycles. After the last microcycle the timing returns to microcycle 1.
- R3: Load (code 0) sets the accumulator to the word stored at the address in bits 11:0.
- R4: Add (code 2) sets the accumulator to the accumulator plus the addressed word, modulo 2^16. AND (code 3) sets it to the bitwise AND of the two.
- R5: Complement (code 4) inverts every accumulator bit. Circular-left (code 5) shifts the accumulator left by one, moving bit 15 into bit 0.
- R6: Store (code 1) writes the accumulator to the word at the address in bits 11:0.
- R7: Jump (code 6) always loads PC from bits 11:0. Jump-if-zero (code 7) does so only when the accumulator is zero; otherwise execution continues at the next address.
- R8: The input register captures in_data on any cycle where in_strobe is high and holds its value otherwise. Input (code 8) copies the input register into the accumulator.
- R9: Output (code 9) copies the accumulator to out_data. out_valid is high for exactly one cycle, the one after the fourth microcycle of that instruction, and out_data holds its value until the next output.
- R10: Halt (code A) sets halted after its fourth microcycle. From then on no microcycle strobe fires and no output happens until reset.
- R11: Codes B to F take 4 cycles and change neither the accumulator nor the store.
- R12: PC counts modulo 4096, so an instruction at address 0xFFF is followed by the one at address 0.
- R13: While ld_en is high, ld_data is written into the store at ld_addr on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write enable for program/data loading |
| ld_addr | input | 12 | Store address for loading |
| ld_data | input | 16 | Word to load |
| in_data | input | 16 | Input port word |
| in_strobe | input | 1 | Captures in_data into the input register |
| out_data | output | 16 | Output register |
| out_valid | output | 1 | One-cycle pulse when out_data is updated |
| halted | output | 1 | Halt flag |

## Verification
Reset is released just before a numbered rising edge, and edges are counted from there. An instruction of k microcycles takes exactly k edges, so halted must first appear after the edge whose number equals the sum of the program's instruction lengths. An output pulse is due right after the edge that closes its instruction's fourth microcycle. The bench samples at the falling edge and compares the edge counter both against the halt cycle and against the first output cycle. All other results reach the ports only through output instructions or through the cycle count, and ten extra cycles after halt confirm that nothing further appears.

// File: rtl/acpu_pkg.sv
package acpu_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 4;
    localparam int NUM_T  = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_LDA = 4'h0,
        OP_STA = 4'h1,
        OP_ADD = 4'h2,
        OP_AND = 4'h3,
        OP_CMA = 4'h4,
        OP_CIL = 4'h5,
        OP_JMP = 4'h6,
        OP_JZ  = 4'h7,
        OP_IN  = 4'h8,
        OP_OUT = 4'h9,
        OP_HLT = 4'hA
    } op_e;

    // One enable per register transfer, plus end-of-instruction
    typedef struct packed {
        logic mar_pc;
        logic mdr_mem;
        logic pc_inc;
        logic opc_ld;
        logic mar_adr;
        logic mdr_ac;
        logic mem_wr;
        logic ac_mdr;
        logic ac_add;
        logic ac_and;
        logic ac_not;
        logic ac_cil;
        logic ac_in;
        logic pc_jmp;
        logic out_ld;
        logic hlt_set;
        logic last;
    } ctl_t;

    function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction

endpackage

// File: rtl/acpu_timing.sv
module acpu_timing #(
    parameter int NT = acpu_pkg::NUM_T
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stop,
    input  logic          last,
    output logic [NT-1:0] strobe_o
);
    logic [NT-1:0] ts;

    always_ff @(posedge clk) begin
        if (rst)       ts <= NT'(1);
        else if (stop) ts <= '0;
        else if (last) ts <= NT'(1);
        else           ts <= ts << 1;
    end

    assign strobe_o = stop ? '0 : ts;

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (last && !stop) |=> (strobe_o[0] || stop));

    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        stop |-> (strobe_o == '0));
endmodule

// File: rtl/acpu_decode.sv
module acpu_decode #(
    parameter int NT = acpu_pkg::NUM_T,
    parameter int OW = acpu_pkg::OPC_W
) (
    input  logic [OW-1:0]    opc,
    input  logic [NT-1:0]    t,
    input  logic             ac_zero,
    output acpu_pkg::ctl_t   c
);
    import acpu_pkg::*;

    logic long_op;
    assign long_op = (opc == OP_LDA) || (opc == OP_ADD) || (opc == OP_AND);

    always_comb begin
        c = '0;
        // fetch
        c.mar_pc  = t[0];
        c.mdr_mem = t[1];
        c.pc_inc  = t[1];
        c.opc_ld  = t[2];
        // execute, microcycle 4
        if (t[3]) begin
            case (opc)
                OP_LDA, OP_ADD, OP_AND: c.mar_adr = 1'b1;
                OP_STA: begin c.mar_adr = 1'b1; c.mdr_ac = 1'b1; end
                OP_CMA: begin c.ac_not  = 1'b1; c.last = 1'b1; end
                OP_CIL: begin c.ac_cil  = 1'b1; c.last = 1'b1; end
                OP_JMP: begin c.pc_jmp  = 1'b1; c.last = 1'b1; end
                OP_JZ:  begin c.pc_jmp  = ac_zero; c.last = 1'b1; end
                OP_IN:  begin c.ac_in   = 1'b1; c.last = 1'b1; end
                OP_OUT: begin c.out_ld  = 1'b1; c.last = 1'b1; end
                OP_HLT: begin c.hlt_set = 1'b1; c.last = 1'b1; end
                default: c.last = 1'b1;
            endcase
        end
        // microcycle 5
        if (t[4]) begin
            if (opc == OP_STA) begin
                c.mem_wr = 1'b1;
                c.last   = 1'b1;
            end else if (long_op) begin
                c.mdr_mem = 1'b1;
            end
        end
        // microcycle 6
        if (t[5]) begin
            c.ac_mdr = (opc == OP_LDA);
            c.ac_add = (opc == OP_ADD);
            c.ac_and = (opc == OP_AND);
            c.last   = 1'b1;
        end
    end
endmodule

// File: rtl/acpu_ram.sv
module acpu_ram #(
    parameter int DW = acpu_pkg::WORD_W,
    parameter int AW = acpu_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/acpu_core.sv
module acpu_core #(
    parameter int DW = acpu_pkg::WORD_W,
    parameter int AW = acpu_pkg::ADDR_W,
    parameter int OW = acpu_pkg::OPC_W,
    parameter int NT = acpu_pkg::NUM_T
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [DW-1:0] in_data,
    input  logic          in_strobe,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          halted
);
    import acpu_pkg::*;

    logic [DW-1:0] ac, mdr, inr, outr, rd_data;
    logic [AW-1:0] pc, mar;
    logic [OW-1:0] opc;
    logic          hlt, ov;
    logic [NT-1:0] strobe;
    ctl_t          c;

    acpu_timing #(.NT(NT)) u_timing (
        .clk(clk), .rst(rst), .stop(hlt), .last(c.last), .strobe_o(strobe)
    );

    acpu_decode #(.NT(NT), .OW(OW)) u_decode (
        .opc(opc), .t(strobe), .ac_zero(ac == '0), .c(c)
    );

    acpu_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk(clk),
        .wr_en(ld_en || c.mem_wr),
        .wr_addr(ld_en ? ld_addr : mar),
        .wr_data(ld_en ? ld_data : mdr),
        .rd_addr(mar),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac   <= '0;
            pc   <= '0;
            mar  <= '0;
            mdr  <= '0;
            opc  <= '0;
            outr <= '0;
            ov   <= 1'b0;
            hlt  <= 1'b0;
        end else begin
            ov <= c.out_ld;
            if (c.mar_pc)       mar <= pc;
            else if (c.mar_adr) mar <= mdr[AW-1:0];
            if (c.mdr_mem)      mdr <= rd_data;
            else if (c.mdr_ac)  mdr <= ac;
            if (c.opc_ld)       opc <= mdr[DW-1 -: OW];
            if (c.pc_inc)       pc  <= pc + 1'b1;
            else if (c.pc_jmp)  pc  <= mdr[AW-1:0];
            if (c.ac_mdr)       ac  <= mdr;
            else if (c.ac_add)  ac  <= ac + mdr;
            else if (c.ac_and)  ac  <= ac & mdr;
            else if (c.ac_not)  ac  <= ~ac;
            else if (c.ac_cil)  ac  <= rotl1(ac);
            else if (c.ac_in)   ac  <= inr;
            if (c.out_ld)       outr <= ac;
            if (c.hlt_set)      hlt <= 1'b1;
        end
    end

    // input register follows its strobe regardless of reset
    always_ff @(posedge clk) begin
        if (in_strobe) inr <= in_data;
    end

    assign out_data  = outr;
    assign out_valid = ov;
    assign halted    = hlt;

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        hlt |=> hlt);

    p_halt_pc_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        hlt |=> ($stable(pc) && !ov));

    p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ov |=> !ov);

    p_cma_inverts_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe[3] && opc == OP_CMA) |=> (ac == ~$past(ac)));

    p_jz_not_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe[3] && opc == OP_JZ && ac != '0) |=> $stable(pc));

    p_fetch_increments_r12: assert property (@(posedge clk) disable iff (rst)
        strobe[1] |=> (pc == $past(pc) + 1'b1));
endmodule

// File: tb/tb_acpu_core.sv
module tb_acpu_core;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] in_data = '0;
    logic        in_strobe = 1'b0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        halted;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_out  = 0;
    logic [15:0] got_val [16];
    int          got_cyc [16];

    always #(CLK_P/2) clk = ~clk;

    acpu_core dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .in_data(in_data), .in_strobe(in_strobe),
        .out_data(out_data), .out_valid(out_valid), .halted(halted)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst) n_out <= 0;
        else if (out_valid && n_out < 16) begin
            got_val[n_out] <= out_data;
            got_cyc[n_out] <= cyc;
            n_out <= n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic start_load();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input string tag, input int exp_cycles);
        int seen;
        rst = 1'b0;
        forever begin
            @(negedge clk);
            if (halted || cyc > 600) break;
        end
        chk(halted == 1'b1, {tag, " R10 halted reached"}, halted, 1);
        chk(cyc == exp_cycles, {tag, " R2 cycles to halt"}, cyc, exp_cycles);
        seen = n_out;
        repeat (10) @(negedge clk);
        chk(halted == 1'b1, {tag, " R10 halt stays"}, halted, 1);
        chk(n_out == seen, {tag, " R10 no output after halt"}, n_out, seen);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(halted == 1'b0, "R1 halted in reset", halted, 0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(out_data == 16'h0, "R1 out_data in reset", out_data, 0);
    endtask

    task automatic t_arith();
        start_load();
        poke(12'h000, 16'h0040); poke(12'h001, 16'h2041); poke(12'h002, 16'h9000);
        poke(12'h003, 16'h3042); poke(12'h004, 16'h9000); poke(12'h005, 16'h4000);
        poke(12'h006, 16'h9000); poke(12'h007, 16'h5000); poke(12'h008, 16'h9000);
        poke(12'h009, 16'h0043); poke(12'h00A, 16'h2044); poke(12'h00B, 16'h9000);
        poke(12'h00C, 16'hA000);
        poke(12'h040, 16'h1234); poke(12'h041, 16'h0FF0); poke(12'h042, 16'hF0F0);
        poke(12'h043, 16'hFFFF); poke(12'h044, 16'h0002);
        run("arith", 62);
        chk(n_out == 5, "R9 arith output count", n_out, 5);
        chk(got_val[0] == 16'h2224, "R3 R4 load then add", got_val[0], 16'h2224);
        chk(got_cyc[0] == 16, "R9 first output cycle", got_cyc[0], 16);
        chk(got_val[1] == 16'h2020, "R4 and", got_val[1], 16'h2020);
        chk(got_cyc[1] == 26, "R9 second output cycle", got_cyc[1], 26);
        chk(got_val[2] == 16'hDFDF, "R5 complement", got_val[2], 16'hDFDF);
        chk(got_val[3] == 16'hBFBF, "R5 circular left", got_val[3], 16'hBFBF);
        chk(got_val[4] == 16'h0001, "R4 add wraps", got_val[4], 16'h0001);
        chk(got_cyc[4] == 58, "R2 output cycle after long ops", got_cyc[4], 58);
        chk(out_data == 16'h0001, "R9 out_data holds", out_data, 16'h0001);
    endtask

    task automatic t_store();
        start_load();
        poke(12'h000, 16'h0040); poke(12'h001, 16'h1100); poke(12'h002, 16'h0041);
        poke(12'h003, 16'h0100); poke(12'h004, 16'h9000); poke(12'h005, 16'hA000);
        poke(12'h040, 16'hA5A5); poke(12'h041, 16'h0000); poke(12'h100, 16'h1111);
        run("store", 31);
        chk(n_out == 1, "R6 store output count", n_out, 1);
        chk(got_val[0] == 16'hA5A5, "R6 R13 stored word read back", got_val[0], 16'hA5A5);
        chk(got_cyc[0] == 27, "R2 store takes five cycles", got_cyc[0], 27);
    endtask

    task automatic t_jump();
        start_load();
        poke(12'h000, 16'h0020); poke(12'h001, 16'h7004); poke(12'h002, 16'h9000);
        poke(12'h003, 16'hA000); poke(12'h004, 16'h0021); poke(12'h005, 16'h7002);
        poke(12'h006, 16'h9000); poke(12'h007, 16'h6009); poke(12'h008, 16'h9000);
        poke(12'h009, 16'hA000);
        poke(12'h020, 16'h0000); poke(12'h021, 16'h0007);
        run("jump", 32);
        chk(n_out == 1, "R7 skipped outputs", n_out, 1);
        chk(got_val[0] == 16'h0007, "R7 jz not taken then output", got_val[0], 7);
        chk(got_cyc[0] == 24, "R7 path timing", got_cyc[0], 24);
    endtask

    task automatic t_input_nop();
        start_load();
        poke(12'h000, 16'h8000); poke(12'h001, 16'h9000); poke(12'h002, 16'hB000);
        poke(12'h003, 16'hF123); poke(12'h004, 16'h9000); poke(12'h005, 16'hA000);
        poke(12'h123, 16'h5555);
        in_data = 16'hBEEF; in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0; in_data = 16'h0000;
        run("input", 24);
        chk(n_out == 2, "R8 R11 output count", n_out, 2);
        chk(got_val[0] == 16'hBEEF, "R8 input captured on strobe", got_val[0], 16'hBEEF);
        chk(got_val[1] == 16'hBEEF, "R11 no-op codes keep accumulator", got_val[1], 16'hBEEF);
        chk(got_cyc[1] == 20, "R11 no-op takes four cycles", got_cyc[1], 20);
    endtask

    task automatic t_wrap();
        start_load();
        poke(12'h000, 16'h7FFE); poke(12'h001, 16'hA000);
        poke(12'hFFE, 16'h4000); poke(12'hFFF, 16'h9000);
        run("wrap", 20);
        chk(n_out == 1, "R12 wrap output count", n_out, 1);
        chk(got_val[0] == 16'hFFFF, "R1 R12 accumulator cleared then complemented", got_val[0], 16'hFFFF);
        chk(got_cyc[0] == 12, "R12 output at top address", got_cyc[0], 12);
    endtask

    task automatic t_nop_store();
        // R11: a no-op code must not write the store; location 0x123 keeps 0x5555
        start_load();
        poke(12'h000, 16'hC123); poke(12'h001, 16'h0123); poke(12'h002, 16'h9000);
        poke(12'h003, 16'hA000);
        run("nop_store", 18);
        chk(got_val[0] == 16'h5555, "R11 no-op leaves store", got_val[0], 16'h5555);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_store();
        t_jump();
        t_input_nop();
        t_nop_store();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog R1..all: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule